// File: doc/BRIEF.md
# SIMD Sign-Mask and Streaming-Store Checker

This unit takes one decoded 128-bit SIMD move instruction per cycle. Each instruction arrives as a 66-prefix flag, the opcode byte that follows the 0F escape, and the ModRM mod field. With it come two feature bits, the relevant control-register bits and the memory-check flags from an external address unit. The unit recognises five forms:

- two sign-mask extracts, which read a 128-bit register and write a zero-extended 32-bit value to a general register;
- three non-temporal stores, which send the 128-bit source to memory.

For each instruction the unit reports exactly one outcome, one cycle after acceptance: a fault vector, a general-register write, or a store request. The store request is marked non-temporal, write-combining and weakly ordered. Faults are checked in a fixed priority order and only the highest one is reported. Address generation, translation, caching and fences belong to other units; their outcomes reach this unit only as input flags.

The unit never stalls. `in_ready` is always high, and every cycle with `in_valid` high is an accepted instruction.

Top module: `simd_mov_check`

## Requirements
- R1: Decode on the byte after 0F. Opcode 50h without the 66 prefix is the single-precision mask extract, and 50h with 66 is the double-precision mask extract. Opcode 2Bh without 66 is the single-precision non-temporal store, and 2Bh with 66 is the double-precision one. Opcode E7h with 66 is the integer non-temporal store. Every other opcode/prefix pair faults with vector 6.
- R2: For the single-precision mask extract, result bits 0, 1, 2 and 3 are source bits 31, 63, 95 and 127, and result bits 31..4 are zero.
- R3: For the double-precision mask extract, result bits 0 and 1 are source bits 63 and 127, and result bits 31..2 are zero.
- R4: Vector 6 is reported in each of these cases: the feature bit needed by the form is clear, `cr0_em` is 1, or `cr4_osfxsr` is 0. Forms without the 66 prefix need `feat_sse`; forms with the 66 prefix need `feat_sse2`.
- R5: Vector 7 is reported when `cr0_ts` is 1 and no vector-6 condition holds.
- R6: A mask extract with mod not equal to 3, or a store with mod equal to 3, faults with vector 6.
- R7: A store with `stk_bad` set faults with vector 12, unless vector 6 or vector 7 applies. Vector 12 takes priority over vector 13.
- R8: A store faults with vector 13 in each of these cases: `addr_lo` (address bits 3..0) is nonzero, or any of `seg_bad`, `seg_null` or `seg_ro` is set. This applies only when no higher-priority fault is present.
- R9: A store with `xlat_flt` set faults with vector 14, only when no other fault applies.
- R10: A store without faults gives `st_valid` with `st_data` equal to the 128-bit source, and with `st_nt`, `st_wc` and `st_weak` all 1.
- R11: The mask extracts ignore `addr_lo`, `stk_bad`, `seg_bad`, `seg_null`, `seg_ro` and `xlat_flt`.
- R12: One cycle after an accepted instruction, exactly one of `flt_valid`, `gpr_we` or `st_valid` is 1. A cycle with `in_valid` low produces none of them one cycle later. Synchronous active-low reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous reset, active low |
| in_valid | input | 1 | instruction present |
| in_ready | output | 1 | always 1 |
| has_66 | input | 1 | 66 operand-size prefix present |
| opc | input | 8 | opcode byte after 0F |
| modrm_mod | input | 2 | ModRM mod field |
| src | input | 128 | source register value |
| feat_sse | input | 1 | first SIMD feature bit (CPUID 1, EDX bit 25) |
| feat_sse2 | input | 1 | second SIMD feature bit (CPUID 1, EDX bit 26) |
| cr0_em | input | 1 | emulate bit |
| cr0_ts | input | 1 | task-switched bit |
| cr4_osfxsr | input | 1 | OS save/restore support bit |
| addr_lo | input | 4 | store address bits 3..0 |
| stk_bad | input | 1 | stack segment limit or non-canonical |
| seg_bad | input | 1 | data segment limit or non-canonical |
| seg_null | input | 1 | null data segment used |
| seg_ro | input | 1 | destination segment not writable |
| xlat_flt | input | 1 | translation reports a page fault |
| flt_valid | output | 1 | fault reported |
| flt_vec | output | 8 | fault vector: 6, 7, 12, 13 or 14 |
| gpr_we | output | 1 | general-register write |
| gpr_val | output | 32 | zero-extended sign mask |
| st_valid | output | 1 | store request |
| st_data | output | 128 | store data |
| st_nt | output | 1 | non-temporal hint |
| st_wc | output | 1 | write-combining type |
| st_weak | output | 1 | weakly ordered |

## Verification
Every outcome is due exactly one clock edge after the cycle in which its instruction is presented; no result takes longer. The bench drives each instruction after a falling edge. It computes the expected output word from its own behavioural model at that moment, then compares the whole registered output at the next falling edge, one rising edge later. Directed vectors cover each form, each fault source and each priority pairing. A long run of biased random vectors then checks the fault priority chain against the model, cycle by cycle.

// File: rtl/simd_mov_check.sv
module simd_mov_check (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         has_66,
  input  logic [7:0]   opc,
  input  logic [1:0]   modrm_mod,
  input  logic [127:0] src,
  input  logic         feat_sse,
  input  logic         feat_sse2,
  input  logic         cr0_em,
  input  logic         cr0_ts,
  input  logic         cr4_osfxsr,
  input  logic [3:0]   addr_lo,
  input  logic         stk_bad,
  input  logic         seg_bad,
  input  logic         seg_null,
  input  logic         seg_ro,
  input  logic         xlat_flt,
  output logic         flt_valid,
  output logic [7:0]   flt_vec,
  output logic         gpr_we,
  output logic [31:0]  gpr_val,
  output logic         st_valid,
  output logic [127:0] st_data,
  output logic         st_nt,
  output logic         st_wc,
  output logic         st_weak
);
  localparam logic [7:0] VEC_UD = 8'd6;
  localparam logic [7:0] VEC_NM = 8'd7;
  localparam logic [7:0] VEC_SS = 8'd12;
  localparam logic [7:0] VEC_GP = 8'd13;
  localparam logic [7:0] VEC_PF = 8'd14;

  logic is_mps, is_mpd, is_store, is_mask, ud, nm, ss, gp, pf, any_flt;
  logic [7:0]  vec;
  logic [31:0] mask;

  assign in_ready = 1'b1;

  assign is_mps   = (opc == 8'h50) && !has_66;
  assign is_mpd   = (opc == 8'h50) && has_66;
  assign is_mask  = is_mps || is_mpd;
  assign is_store = (opc == 8'h2B) || ((opc == 8'hE7) && has_66);

  assign ud = !(is_mask || is_store)
           || !(has_66 ? feat_sse2 : feat_sse)
           || cr0_em || !cr4_osfxsr
           || (is_mask && modrm_mod != 2'd3)
           || (is_store && modrm_mod == 2'd3);
  assign nm = cr0_ts;
  assign ss = is_store && stk_bad;
  assign gp = is_store && ((addr_lo != 4'd0) || seg_bad || seg_null || seg_ro);
  assign pf = is_store && xlat_flt;
  assign any_flt = ud || nm || ss || gp || pf;

  always_comb begin
    if (ud)      vec = VEC_UD;
    else if (nm) vec = VEC_NM;
    else if (ss) vec = VEC_SS;
    else if (gp) vec = VEC_GP;
    else         vec = VEC_PF;
  end

  assign mask = is_mpd ? {30'd0, src[127], src[63]}
                       : {28'd0, src[127], src[95], src[63], src[31]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt_valid <= 1'b0;
      flt_vec   <= 8'd0;
      gpr_we    <= 1'b0;
      gpr_val   <= 32'd0;
      st_valid  <= 1'b0;
      st_data   <= 128'd0;
      st_nt     <= 1'b0;
      st_wc     <= 1'b0;
      st_weak   <= 1'b0;
    end else begin
      flt_valid <= in_valid && any_flt;
      flt_vec   <= (in_valid && any_flt) ? vec : 8'd0;
      gpr_we    <= in_valid && !any_flt && is_mask;
      gpr_val   <= (in_valid && !any_flt && is_mask) ? mask : 32'd0;
      st_valid  <= in_valid && !any_flt && is_store;
      st_data   <= (in_valid && !any_flt && is_store) ? src : 128'd0;
      st_nt     <= in_valid && !any_flt && is_store;
      st_wc     <= in_valid && !any_flt && is_store;
      st_weak   <= in_valid && !any_flt && is_store;
    end
  end
endmodule

module simd_mov_check_sva (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         has_66,
  input logic [7:0]   opc,
  input logic [1:0]   modrm_mod,
  input logic [127:0] src,
  input logic         feat_sse,
  input logic         feat_sse2,
  input logic         cr0_em,
  input logic         cr0_ts,
  input logic         cr4_osfxsr,
  input logic         flt_valid,
  input logic [7:0]   flt_vec,
  input logic         gpr_we,
  input logic [31:0]  gpr_val,
  input logic         st_valid,
  input logic [127:0] st_data
);
  p_one_outcome_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> $countones({flt_valid, gpr_we, st_valid}) == 1);
  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !(flt_valid || gpr_we || st_valid));
  p_ps_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gpr_we |-> gpr_val[31:4] == 28'd0);
  p_pd_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && has_66) |=> (!gpr_we || gpr_val[31:2] == 30'd0));
  p_store_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (!st_valid || st_data == $past(src)));
  p_em_ud_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cr0_em) |=> (flt_valid && flt_vec == 8'd6));
  p_ts_nm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cr0_ts && !cr0_em && cr4_osfxsr && opc == 8'h50 && modrm_mod == 2'd3
     && (has_66 ? feat_sse2 : feat_sse)) |=> (flt_valid && flt_vec == 8'd7));
endmodule

bind simd_mov_check simd_mov_check_sva u_sva (.*);

// File: tb/test_simd_mov_check.sv
`timescale 1ns/1ps
module test_simd_mov_check;
  localparam int W = 1 + 8 + 1 + 32 + 1 + 128 + 3;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, has_66 = 1'b0;
  logic [7:0] opc = 8'h00;
  logic [1:0] modrm_mod = 2'd0;
  logic [127:0] src = '0;
  logic feat_sse = 1'b1, feat_sse2 = 1'b1, cr0_em = 1'b0, cr0_ts = 1'b0, cr4_osfxsr = 1'b1;
  logic [3:0] addr_lo = 4'd0;
  logic stk_bad = 1'b0, seg_bad = 1'b0, seg_null = 1'b0, seg_ro = 1'b0, xlat_flt = 1'b0;
  logic in_ready, flt_valid, gpr_we, st_valid, st_nt, st_wc, st_weak;
  logic [7:0] flt_vec;
  logic [31:0] gpr_val;
  logic [127:0] st_data;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  simd_mov_check i_simd_mov_check (.*);

  function automatic logic [W-1:0] model();
    int v;
    bit mask_form, store_form, fault;
    logic [31:0] m;
    if (!rst_n || !in_valid) return '0;
    mask_form  = (opc == 8'h50);
    store_form = (opc == 8'h2B) || (opc == 8'hE7 && has_66);
    v = 0;
    if (!mask_form && !store_form) v = 6;
    else if (has_66 && !feat_sse2) v = 6;
    else if (!has_66 && !feat_sse) v = 6;
    else if (cr0_em || !cr4_osfxsr) v = 6;
    else if (mask_form && modrm_mod != 3) v = 6;
    else if (store_form && modrm_mod == 3) v = 6;
    else if (cr0_ts) v = 7;
    else if (store_form && stk_bad) v = 12;
    else if (store_form && (addr_lo != 0 || seg_bad || seg_null || seg_ro)) v = 13;
    else if (store_form && xlat_flt) v = 14;
    fault = (v != 0);
    if (fault) return {1'b1, 8'(v), 1'b0, 32'd0, 1'b0, 128'd0, 3'b000};
    if (mask_form) begin
      m = 0;
      if (has_66) begin m[0] = src[63]; m[1] = src[127]; end
      else begin m[0] = src[31]; m[1] = src[63]; m[2] = src[95]; m[3] = src[127]; end
      return {1'b0, 8'd0, 1'b1, m, 1'b0, 128'd0, 3'b000};
    end
    return {1'b0, 8'd0, 1'b0, 32'd0, 1'b1, src, 3'b111};
  endfunction

  task automatic step(input string tag);
    logic [W-1:0] exp, act;
    exp = model();
    @(negedge clk);
    act = {flt_valid, flt_vec, gpr_we, gpr_val, st_valid, st_data, st_nt, st_wc, st_weak};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic base();
    in_valid = 1'b1; has_66 = 1'b0; opc = 8'h50; modrm_mod = 2'd3;
    feat_sse = 1'b1; feat_sse2 = 1'b1; cr0_em = 1'b0; cr0_ts = 1'b0; cr4_osfxsr = 1'b1;
    addr_lo = 4'd0; stk_bad = 1'b0; seg_bad = 1'b0; seg_null = 1'b0; seg_ro = 1'b0; xlat_flt = 1'b0;
  endtask

  task automatic store(input logic p66, input logic [7:0] o);
    base(); has_66 = p66; opc = o; modrm_mod = 2'd0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    in_valid = 1'b1; opc = 8'h50; modrm_mod = 2'd3;
    step("R12 reset"); step("R12 reset");
    rst_n = 1'b1;
    // R2 single-precision mask
    base(); src = {1'b1, 31'd0, 1'b0, 31'h7fffffff, 1'b1, 31'd0, 1'b0, 31'h7fffffff}; step("R2");
    base(); src = {4{32'h80000000}}; step("R2");
    // R3 double-precision mask, bits 31 and 95 must not appear
    base(); has_66 = 1'b1; src = {1'b0, 31'd0, 32'hffffffff, 1'b1, 63'h0000_0000_ffff_ffff}; step("R3");
    base(); has_66 = 1'b1; src = {1'b1, 63'd0, 1'b0, 63'h7fffffffffffffff}; step("R3");
    // R1 decode
    base(); opc = 8'h51; step("R1");
    store(1'b0, 8'hE7); step("R1");
    store(1'b0, 8'h2B); src = {4{32'hdeadbeef}}; step("R1");
    store(1'b1, 8'h2B); src = {2{64'h0123456789abcdef}}; step("R1");
    store(1'b1, 8'hE7); src = 128'h00112233445566778899aabbccddeeff; step("R10");
    // R4 feature and control bits
    base(); feat_sse = 1'b0; step("R4");
    base(); has_66 = 1'b1; feat_sse = 1'b0; step("R4");
    store(1'b1, 8'hE7); feat_sse2 = 1'b0; step("R4");
    store(1'b0, 8'h2B); feat_sse2 = 1'b0; step("R4");
    base(); cr0_em = 1'b1; step("R4");
    base(); cr4_osfxsr = 1'b0; step("R4");
    // R5
    base(); cr0_ts = 1'b1; step("R5");
    base(); cr0_ts = 1'b1; cr0_em = 1'b1; step("R5");
    store(1'b1, 8'h2B); cr0_ts = 1'b1; stk_bad = 1'b1; step("R5");
    // R6
    base(); modrm_mod = 2'd1; step("R6");
    store(1'b0, 8'h2B); modrm_mod = 2'd3; step("R6");
    // R7
    store(1'b0, 8'h2B); stk_bad = 1'b1; seg_bad = 1'b1; step("R7");
    // R8
    store(1'b1, 8'hE7); addr_lo = 4'd8; step("R8");
    store(1'b1, 8'hE7); seg_null = 1'b1; step("R8");
    store(1'b1, 8'h2B); seg_ro = 1'b1; step("R8");
    store(1'b0, 8'h2B); seg_bad = 1'b1; step("R8");
    // R9
    store(1'b0, 8'h2B); xlat_flt = 1'b1; step("R9");
    store(1'b0, 8'h2B); xlat_flt = 1'b1; seg_ro = 1'b1; step("R9");
    // R11
    base(); src = {4{32'h80000000}}; addr_lo = 4'd3; stk_bad = 1'b1; seg_bad = 1'b1;
    seg_null = 1'b1; seg_ro = 1'b1; xlat_flt = 1'b1; step("R11");
    // R12 idle
    base(); in_valid = 1'b0; step("R12");
    // R12 random sweep
    for (int i = 0; i < 600; i++) begin
      int r;
      in_valid = ($urandom % 8) != 0;
      has_66 = $urandom % 2;
      r = $urandom % 4;
      opc = (r == 0) ? 8'h50 : (r == 1) ? 8'h2B : (r == 2) ? 8'hE7 : 8'($urandom);
      modrm_mod = 2'($urandom);
      src = {$urandom, $urandom, $urandom, $urandom};
      feat_sse = ($urandom % 10) != 0; feat_sse2 = ($urandom % 10) != 0;
      cr0_em = ($urandom % 12) == 0; cr0_ts = ($urandom % 8) == 0;
      cr4_osfxsr = ($urandom % 12) != 0;
      addr_lo = (($urandom % 4) == 0) ? 4'($urandom) : 4'd0;
      stk_bad = ($urandom % 6) == 0; seg_bad = ($urandom % 8) == 0;
      seg_null = ($urandom % 10) == 0; seg_ro = ($urandom % 10) == 0;
      xlat_flt = ($urandom % 5) == 0;
      step("R12 random");
    end
    checks++;
    if (in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R12 in_ready: actual %b expected 1", in_ready);
    end
    rst_n = 1'b0; base(); step("R12 reset again");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule